// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Read Copy

This block keeps wall-clock time and calendar date for a bytewide memory-mapped peripheral. It sits in the top eight byte addresses of an 8K x 8 address space. Century, year, month, date, day-of-week, hours, minutes and seconds are held as packed BCD, with hours in 24-hour form. A single-cycle `tick` pulse, one per second and synchronous to `clk`, advances a set of internal counters. The whole rollover chain from seconds to century settles in that one cycle. Month lengths are corrected automatically, and every year divisible by four counts as a leap year.

Software never reads the internal counters directly. It reads a second, visible register set. While the hold bit (bit 6 of the century byte) is 0, this set is copied from the counters on every clock. Setting the hold bit freezes the visible set at the count current at that moment, so a multi-byte read cannot straddle a rollover. Timekeeping carries on underneath, and clearing the bit refreshes every visible byte together. Addresses below the clock window are left to an external storage array: `sel_clk` shows when the clock window is addressed, and the block returns zero there.

Top module: `bcd_rtc`

## Requirements
- R1: The eight top addresses map as follows: 0x1FF8 century/control, 0x1FF9 seconds, 0x1FFA minutes, 0x1FFB hours, 0x1FFC day-of-week, 0x1FFD date, 0x1FFE month, 0x1FFF year. `sel_clk` is high only when `ce` is high and the address is one of these. Accesses to any other address neither read nor change clock state.
- R2: Stored widths are: seconds and minutes 7 bits, hours and date 6 bits, day 3 bits, month 5 bits, year 8 bits, century value 6 bits (bits 5:0). Bit 7 of the century byte reads 0. Written bits above a field's width are discarded and read as 0.
- R3: A tick increments seconds in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes, minutes 0x59 carries into hours, and hours 0x23 wraps to 0x00 and carries into the date.
- R4: The date wraps to 0x01 and carries into the month after its month's last day: 0x31 for months 01, 03, 05, 07, 08, 10 and 12; 0x30 for months 04, 06, 09 and 11; February 0x29 when the year value is divisible by 4, else 0x28. Month 0x12 wraps to 0x01 and carries into the year.
- R5: Day-of-week advances at midnight (the hours carry) and runs 1 through 7, then back to 1.
- R6: Year 0x99 wraps to 0x00 and carries into the century. Century 0x39 wraps to 0x00.
- R7: Writing 1 to century bit 6 freezes the visible registers at the counts present in that cycle. They stay frozen while the bit remains 1, except for bytes written from the bus.
- R8: The internal counters keep counting while frozen. Two clocks after the bit is written back to 0, every visible byte shows the current count.
- R9: A bus write to a clock register loads the internal counter and the visible copy together. A tick in the same cycle is ignored for that register.
- R10: A read (`ce`, `oe` high, `we` low) returns the addressed visible byte on `dout` one clock later. In every other cycle `dout` is 0x00 one clock later.
- R11: After reset the clock reads 2000-01-01, day 1, 00:00:00, with the hold bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, one per second |
| addr | input | ADDR_W (13) | Byte address |
| din | input | 8 | Write data |
| ce | input | 1 | Chip enable, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| dout | output | 8 | Registered read data, zero when not reading |
| sel_clk | output | 1 | Clock window is addressed while enabled |

## Verification
The bench checks February 28 for all hundred years and the last day of every month over four years. A faulty leap rule or month table would show up here as a February 29 that appears in the wrong years or a 31st that rolls over too early. A run of 90061 back-to-back ticks crosses midnight with a leap day, and a cascade that drops a carry would leave the hours or the weekday behind the arithmetic total. The freeze tests set the hold bit while ticking, write a byte while frozen and then release. A copy that leaked updates, or one that refreshed only some bytes, would return seconds other than the captured or current value. The year 99 and century 39 wraps, writes that land together with a tick, masked high bits and addresses just below the window are also exercised.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  output logic [7:0]        dout,
  output logic              sel_clk
);
  localparam int NREG = 8;
  localparam int HOLD_BIT = 6;

  logic [7:0] cnt [NREG];
  logic [7:0] vis [NREG];
  logic [7:0] nxt [NREG];
  logic       hold;

  logic [63:0] cnt_flat, vis_flat;

  wire       in_win = &addr[ADDR_W-1:3];
  wire [2:0] idx    = addr[2:0];
  assign sel_clk = ce && in_win;
  wire wr_hit = sel_clk && we;
  wire rd_hit = sel_clk && oe && !we;

  function automatic logic [7:0] fmask(input int i);
    case (i)
      0:       return 8'h3F;
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fresh(input int i);
    case (i)
      0:       return 8'h20;
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  logic       leap;
  logic [7:0] last_day;
  logic       c_sec, c_min, c_hr, c_date, c_mon, c_yr;

  always_comb begin
    leap = (cnt[7][1:0] + {cnt[7][4], 1'b0}) == 2'b00;
    case (cnt[6])
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c_sec  = cnt[1] == 8'h59;
  assign c_min  = c_sec  && cnt[2] == 8'h59;
  assign c_hr   = c_min  && cnt[3] == 8'h23;
  assign c_date = c_hr   && cnt[5] == last_day;
  assign c_mon  = c_date && cnt[6] == 8'h12;
  assign c_yr   = c_mon  && cnt[7] == 8'h99;

  always_comb begin
    nxt[1] = c_sec ? 8'h00 : binc(cnt[1]);
    nxt[2] = !c_sec ? cnt[2] : (c_min ? 8'h00 : binc(cnt[2]));
    nxt[3] = !c_min ? cnt[3] : (c_hr ? 8'h00 : binc(cnt[3]));
    nxt[4] = !c_hr ? cnt[4] : (cnt[4] == 8'h07 ? 8'h01 : cnt[4] + 8'h01);
    nxt[5] = !c_hr ? cnt[5] : (c_date ? 8'h01 : binc(cnt[5]));
    nxt[6] = !c_date ? cnt[6] : (c_mon ? 8'h01 : binc(cnt[6]));
    nxt[7] = !c_mon ? cnt[7] : (c_yr ? 8'h00 : binc(cnt[7]));
    nxt[0] = !c_yr ? cnt[0] : (cnt[0] == 8'h39 ? 8'h00 : binc(cnt[0]));
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt[g] <= fresh(g);
          vis[g] <= fresh(g);
        end else if (wr_hit && idx == 3'(g)) begin
          cnt[g] <= din & fmask(g);
          vis[g] <= din & fmask(g);
        end else begin
          if (tick) cnt[g] <= nxt[g] & fmask(g);
          if (!hold) vis[g] <= cnt[g];
        end
      end
      assign cnt_flat[8*g +: 8] = cnt[g];
      assign vis_flat[8*g +: 8] = vis[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
      dout <= 8'h00;
    end else begin
      if (wr_hit && idx == 3'd0) hold <= din[HOLD_BIT];
      if (!rd_hit)        dout <= 8'h00;
      else if (idx == 3'd0) dout <= {1'b0, hold, vis[0][5:0]};
      else                dout <= vis[idx];
    end
  end
endmodule

module bcd_rtc_props #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        din,
  input logic              ce,
  input logic              we,
  input logic              oe,
  input logic [7:0]        dout,
  input logic              hold,
  input logic [63:0]       cnt_flat,
  input logic [63:0]       vis_flat
);
  wire any_wr = ce && we && (&addr[ADDR_W-1:3]);
  wire at_midnight = cnt_flat[15:8] == 8'h59 && cnt_flat[23:16] == 8'h59 && cnt_flat[31:24] == 8'h23;

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && oe && !we) |=> dout == 8'h00);
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !any_wr) |=> $stable(vis_flat));
  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !any_wr) |=> vis_flat == $past(cnt_flat));
  p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_wr && at_midnight) |=> cnt_flat[31:8] == 24'h0);
  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_wr && at_midnight && cnt_flat[39:32] == 8'h07) |=> cnt_flat[39:32] == 8'h01);
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && addr[2:0] == 3'd1) |=> cnt_flat[15:8] == ($past(din) & 8'h7F));
endmodule

bind bcd_rtc bcd_rtc_props #(.ADDR_W(ADDR_W)) u_props (
  .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .din(din),
  .ce(ce), .we(we), .oe(oe), .dout(dout), .hold(hold),
  .cnt_flat(cnt_flat), .vis_flat(vis_flat)
);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  logic        clk = 0, rst_n = 0, tick = 0, ce = 0, we = 0, oe = 0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        sel_clk;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [12:0] A_CEN = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
    A_HR = 13'h1FFB, A_DAY = 13'h1FFC, A_DATE = 13'h1FFD, A_MON = 13'h1FFE, A_YR = 13'h1FFF;

  bcd_rtc uut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .din(din),
    .dout(dout), .sel_clk(sel_clk), .ce(ce), .we(we), .oe(oe));

  always #5 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic t = 0);
    @(negedge clk);
    addr = a; din = d; ce = 1; we = 1; tick = t;
    @(negedge clk);
    ce = 0; we = 0; tick = 0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce = 1; oe = 1; we = 0;
    @(negedge clk);
    d = dout; ce = 0; oe = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic set_all(input int c, input int y, input int m, input int dt,
                         input int dw, input int h, input int mi, input int s);
    wr(A_CEN, bcd(c)); wr(A_YR, bcd(y)); wr(A_MON, bcd(m)); wr(A_DATE, bcd(dt));
    wr(A_DAY, 8'(dw)); wr(A_HR, bcd(h)); wr(A_MIN, bcd(mi)); wr(A_SEC, bcd(s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R10 reset dout", dout, 8'h00);
    rst_n = 1;

    rd(A_CEN, v); chk("R11 century", v, 8'h20);
    rd(A_YR, v);  chk("R11 year", v, 8'h00);
    rd(A_MON, v); chk("R11 month", v, 8'h01);
    rd(A_DATE, v); chk("R11 date", v, 8'h01);
    rd(A_DAY, v); chk("R11 day", v, 8'h01);
    rd(A_HR, v);  chk("R11 hours", v, 8'h00);
    rd(A_MIN, v); chk("R11 minutes", v, 8'h00);
    rd(A_SEC, v); chk("R11 seconds", v, 8'h00);

    // R1: window decode and outside addresses
    @(negedge clk); addr = A_SEC; ce = 1; #1;
    chk("R1 sel in window", {7'h0, sel_clk}, 8'h01);
    addr = 13'h1FF7; #1;
    chk("R1 sel below window", {7'h0, sel_clk}, 8'h00);
    ce = 0;
    wr(A_SEC, 8'h17);
    wr(13'h1FF7, 8'h55);
    wr(13'h0001, 8'h33);
    rd(A_SEC, v);     chk("R1 outside write ignored", v, 8'h17);
    rd(13'h1FF7, v);  chk("R1 outside read zero", v, 8'h00);
    @(negedge clk); addr = A_SEC; ce = 1; we = 0; oe = 0;
    @(negedge clk); chk("R10 no oe gives zero", dout, 8'h00); ce = 0;

    // R2: masking
    wr(A_MON, 8'hF2); rd(A_MON, v); chk("R2 month mask", v, 8'h12);
    wr(A_DAY, 8'hFD); rd(A_DAY, v); chk("R2 day mask", v, 8'h05);
    wr(A_CEN, 8'hA1); rd(A_CEN, v); chk("R2 century mask", v, 8'h21);

    // R3: second/minute/hour cascade sweep over one hour
    set_all(20, 0, 1, 1, 1, 5, 0, 0);
    ticks(3599);
    rd(A_SEC, v); chk("R3 seconds after 3599", v, bcd(59));
    rd(A_MIN, v); chk("R3 minutes after 3599", v, bcd(59));
    rd(A_HR, v);  chk("R3 hours after 3599", v, bcd(5));
    ticks(1);
    rd(A_SEC, v); chk("R3 seconds wrap", v, 8'h00);
    rd(A_HR, v);  chk("R3 hour carry", v, bcd(6));

    // R4: February in every year
    for (int y = 0; y < 100; y++) begin
      set_all(20, y, 2, 28, 1, 23, 59, 59);
      ticks(1);
      rd(A_DATE, v);
      chk($sformatf("R4 feb28 year %0d", y), v, (y % 4 == 0) ? 8'h29 : 8'h01);
    end
    // R4: last day of every month over four years
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_all(20, y, m, mdays(m, y), 2, 23, 59, 59);
        ticks(1);
        rd(A_DATE, v); chk($sformatf("R4 date wrap m%0d y%0d", m, y), v, 8'h01);
        rd(A_MON, v);  chk($sformatf("R4 month m%0d y%0d", m, y), v, bcd(m % 12 + 1));
        rd(A_YR, v);   chk($sformatf("R4 year m%0d y%0d", m, y), v, bcd(m == 12 ? y + 1 : y));
        set_all(20, y, m, mdays(m, y) - 1, 2, 23, 59, 59);
        ticks(1);
        rd(A_DATE, v); chk($sformatf("R4 no early wrap m%0d y%0d", m, y), v, bcd(mdays(m, y)));
      end
    end

    // R5: weekday
    for (int d = 1; d <= 7; d++) begin
      set_all(20, 1, 3, 10, d, 23, 59, 59);
      ticks(1);
      rd(A_DAY, v); chk($sformatf("R5 weekday from %0d", d), v, 8'(d % 7 + 1));
    end
    set_all(20, 1, 3, 10, 4, 22, 59, 59);
    ticks(1);
    rd(A_DAY, v); chk("R5 no advance before midnight", v, 8'h04);

    // R6: year and century
    set_all(19, 99, 12, 31, 3, 23, 59, 59);
    ticks(1);
    rd(A_YR, v);  chk("R6 year wrap", v, 8'h00);
    rd(A_CEN, v); chk("R6 century carry", v, 8'h20);
    set_all(39, 99, 12, 31, 3, 23, 59, 59);
    ticks(1);
    rd(A_CEN, v); chk("R6 century wrap", v, 8'h00);

    // long run: 2024-02-28 00:00:00 day 3 + 90061 s
    set_all(20, 24, 2, 28, 3, 0, 0, 0);
    ticks(90061);
    rd(A_DATE, v); chk("R4 long run date", v, 8'h29);
    rd(A_DAY, v);  chk("R5 long run day", v, 8'h04);
    rd(A_HR, v);   chk("R3 long run hours", v, 8'h01);
    rd(A_MIN, v);  chk("R3 long run minutes", v, 8'h01);
    rd(A_SEC, v);  chk("R3 long run seconds", v, 8'h01);

    // R7/R8: freeze and release
    set_all(20, 5, 6, 15, 2, 10, 0, 0);
    wr(A_CEN, 8'h60);
    ticks(5);
    rd(A_SEC, v); chk("R7 frozen seconds", v, 8'h00);
    rd(A_CEN, v); chk("R7 hold bit reads back", v, 8'h60);
    wr(A_CEN, 8'h20);
    rd(A_SEC, v); chk("R8 refreshed seconds", v, 8'h05);
    rd(A_CEN, v); chk("R8 hold cleared", v, 8'h20);
    set_all(20, 5, 6, 15, 2, 10, 59, 58);
    wr(A_CEN, 8'h60);
    ticks(3);
    rd(A_MIN, v); chk("R7 frozen minutes", v, bcd(59));
    rd(A_HR, v);  chk("R7 frozen hours", v, bcd(10));
    wr(A_CEN, 8'h20);
    rd(A_HR, v);  chk("R8 hours after release", v, bcd(11));
    rd(A_MIN, v); chk("R8 minutes after release", v, 8'h00);
    rd(A_SEC, v); chk("R8 seconds after release", v, 8'h01);

    // R9: write while frozen and write racing a tick
    wr(A_CEN, 8'h60);
    wr(A_SEC, 8'h30);
    rd(A_SEC, v); chk("R9 write visible while frozen", v, 8'h30);
    wr(A_CEN, 8'h20);
    wr(A_SEC, 8'h42, 1'b1);
    rd(A_SEC, v); chk("R9 tick ignored on written reg", v, 8'h42);
    ticks(1);
    rd(A_SEC, v); chk("R9 counts from written value", v, 8'h43);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule